// File: doc/BRIEF.md
# Receive Collision-Window Buffer Gate

This block sits after a receive FIFO and decides whether, and when, the bytes of an incoming frame are written into host receive buffers. Bytes arrive on a valid/ready input stream with an end-of-frame marker. The first WIN bytes (64 by default) are held in a local staging store. After the eighth byte the block pulses a check request to an external address filter. The filter may answer with a reject pulse at any point up to and including the cycle of the 64th byte. A frame that ends inside the window, or that is rejected inside it, never produces a buffer write.

Once the window is complete and no reject has been seen, the staged bytes are written in order into the current buffer, starting at address 0. The block then forwards live bytes straight from the input to the write port. A full buffer is closed with a done strobe. The block then requests the next descriptor and continues at address 0 of that buffer if it is empty. If it is not empty, the rest of the frame is dropped and an overrun flag is raised. The final buffer of a frame is closed with a last flag and its byte count.

Both streams follow valid/ready rules. A transfer happens on a rising clock edge where valid and ready are both high. While staged bytes are being written, `in_ready` is low. While live bytes are forwarded, `in_ready` follows `wr_ready`, so back-pressure on the write port stalls the input. A source must hold its data stable while valid is high and ready is low.

Top module: `rx_window_gate`

## Requirements
- R1: `in_ready` is high while collecting or discarding, low while staged bytes are written out, and equal to `wr_ready` while live bytes are forwarded; no byte is lost or repeated under write-port back-pressure.
- R2: `filt_chk` pulses for exactly one cycle, one clock after the eighth byte of a frame is accepted, once per frame of at least eight bytes.
- R3: A frame whose end marker comes with fewer than 64 bytes produces no `wr_valid` and no `buf_done`.
- R4: An `addr_reject` pulse seen while any of bytes 1 to 64 is being collected (including the cycle the 64th is accepted) makes the whole frame produce no write and no `buf_done`.
- R5: An `addr_reject` after the 64th byte has been accepted has no effect on the frame's writes.
- R6: Frame byte i (from 0) is written with data equal to the byte received, at address i modulo BUF_BYTES, in arrival order.
- R7: Writing to address BUF_BYTES-1 when it is not the frame's last byte gives, one cycle later, `buf_done`=1, `buf_last`=0, `buf_count`=BUF_BYTES and `desc_advance`=1; if `next_desc_empty` was 1 on that write, the frame continues at address 0.
- R8: If `next_desc_empty` is 0 on such a spill write, no further byte of the frame is written and `overrun` becomes 1; it stays 1 until the first byte of the next frame is accepted.
- R9: One cycle after the frame's last byte is written, `buf_done`=1, `buf_last`=1 and `buf_count` equals the bytes in that buffer (1 to BUF_BYTES), with `desc_advance`=0.
- R10: `buf_irq` equals `buf_done` when `irq_en` was 1 on the closing write, and is 0 otherwise.
- R11: After reset `in_ready`=1 and `wr_valid`, `buf_done`, `buf_irq`, `desc_advance`, `filt_chk` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Marks the frame's final byte |
| addr_reject | input | 1 | Reject pulse from the address filter |
| filt_chk | output | 1 | Request to the filter after the eighth byte |
| wr_valid | output | 1 | Buffer write valid |
| wr_ready | input | 1 | Buffer write accepted |
| wr_addr | output | 6 | Byte address in the current buffer |
| wr_data | output | 8 | Byte to write |
| next_desc_empty | input | 1 | Next descriptor is free for a spill |
| irq_en | input | 1 | Buffer interrupt mask enable |
| buf_done | output | 1 | Current buffer closed (clears its empty flag) |
| buf_last | output | 1 | Closed buffer holds the frame's end |
| buf_count | output | 6 | Bytes in the closed buffer |
| buf_irq | output | 1 | Masked buffer interrupt |
| desc_advance | output | 1 | Request to move to the next descriptor |
| overrun | output | 1 | Spill found no empty descriptor |

## Verification
The bench sends frames of 40, 63 and exactly 64 bytes. A gate that counted the window off by one would write a 63-byte fragment or lose the 64-byte frame. It places rejects at byte 10, exactly at byte 64 and at byte 70. A design that sampled the reject a cycle late would write the byte-64 case, and one that kept listening after the window would drop the byte-70 frame. Frames that end exactly on a buffer boundary, spill several times, or meet an occupied next descriptor expose wrong counts, a missing last flag, or writes past an overrun. A random stall pattern on `wr_ready` catches any byte lost or duplicated at the switch from staged to live data.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  typedef enum logic [1:0] {
    GS_COLLECT = 2'd0,
    GS_DRAIN   = 2'd1,
    GS_LIVE    = 2'd2,
    GS_DROP    = 2'd3
  } gate_st_e;
endpackage

// File: rtl/rxg_stage.sv
module rxg_stage #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxg_buf_track.sv
module rxg_buf_track #(
  parameter int BUF_BYTES = 48,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int CW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          wr_fire,
  input  logic          wr_end,
  input  logic          next_empty,
  input  logic          irq_en,
  output logic [AW-1:0] addr,
  output logic          spill_fail,
  output logic          done,
  output logic          last,
  output logic [CW-1:0] count,
  output logic          irq,
  output logic          advance,
  output logic          ovr
);
  logic full_now;

  assign full_now   = (addr == AW'(BUF_BYTES - 1));
  assign spill_fail = wr_fire && full_now && !wr_end && !next_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      done    <= 1'b0;
      last    <= 1'b0;
      count   <= '0;
      irq     <= 1'b0;
      advance <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      done    <= 1'b0;
      irq     <= 1'b0;
      advance <= 1'b0;
      if (frame_start) ovr <= 1'b0;
      if (wr_fire) begin
        if (wr_end || full_now) begin
          done  <= 1'b1;
          last  <= wr_end;
          count <= CW'(addr) + CW'(1);
          irq   <= irq_en;
          addr  <= '0;
          if (!wr_end) begin
            advance <= 1'b1;
            if (!next_empty) ovr <= 1'b1;
          end
        end else begin
          addr <= addr + AW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rx_window_gate.sv
module rx_window_gate
  import rxg_pkg::*;
#(
  parameter int WIN       = 64,
  parameter int BUF_BYTES = 48,
  parameter int DW        = 8,
  parameter int CHK_AT    = 8,
  localparam int SAW = $clog2(WIN),
  localparam int CNW = $clog2(WIN + 1),
  localparam int BAW = $clog2(BUF_BYTES),
  localparam int BCW = $clog2(BUF_BYTES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  input  logic           in_last,
  input  logic           addr_reject,
  output logic           filt_chk,
  output logic           wr_valid,
  input  logic           wr_ready,
  output logic [BAW-1:0] wr_addr,
  output logic [DW-1:0]  wr_data,
  input  logic           next_desc_empty,
  input  logic           irq_en,
  output logic           buf_done,
  output logic           buf_last,
  output logic [BCW-1:0] buf_count,
  output logic           buf_irq,
  output logic           desc_advance,
  output logic           overrun
);
  gate_st_e       st;
  logic [CNW-1:0] col_cnt;
  logic [SAW-1:0] rd_ptr;
  logic           rej_seen;
  logic           end_staged;
  logic           acc;
  logic           wr_fire;
  logic           wr_end;
  logic           spill_fail;
  logic           frame_start;
  logic           win_full;
  logic           stage_we;
  logic [DW-1:0]  stage_q;

  // input side handshake
  always_comb begin
    unique case (st)
      GS_COLLECT: in_ready = 1'b1;
      GS_DRAIN:   in_ready = 1'b0;
      GS_LIVE:    in_ready = wr_ready;
      default:    in_ready = 1'b1;
    endcase
  end

  assign acc         = in_valid && in_ready;
  assign stage_we    = (st == GS_COLLECT) && acc;
  assign frame_start = stage_we && (col_cnt == '0);
  assign win_full    = stage_we && (col_cnt == CNW'(WIN - 1));

  // write side
  always_comb begin
    wr_valid = 1'b0;
    wr_data  = in_data;
    wr_end   = 1'b0;
    unique case (st)
      GS_DRAIN: begin
        wr_valid = 1'b1;
        wr_data  = stage_q;
        wr_end   = end_staged && (rd_ptr == SAW'(WIN - 1));
      end
      GS_LIVE: begin
        wr_valid = in_valid;
        wr_end   = in_last;
      end
      default: ;
    endcase
  end

  assign wr_fire = wr_valid && wr_ready;

  rxg_stage #(.DEPTH(WIN), .DW(DW)) u_stage (
    .clk   (clk),
    .we    (stage_we),
    .waddr (col_cnt[SAW-1:0]),
    .wdata (in_data),
    .raddr (rd_ptr),
    .rdata (stage_q)
  );

  rxg_buf_track #(.BUF_BYTES(BUF_BYTES)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .wr_fire     (wr_fire),
    .wr_end      (wr_end),
    .next_empty  (next_desc_empty),
    .irq_en      (irq_en),
    .addr        (wr_addr),
    .spill_fail  (spill_fail),
    .done        (buf_done),
    .last        (buf_last),
    .count       (buf_count),
    .irq         (buf_irq),
    .advance     (desc_advance),
    .ovr         (overrun)
  );

  // frame sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= GS_COLLECT;
      col_cnt    <= '0;
      rd_ptr     <= '0;
      rej_seen   <= 1'b0;
      end_staged <= 1'b0;
      filt_chk   <= 1'b0;
    end else begin
      filt_chk <= stage_we && (col_cnt == CNW'(CHK_AT - 1));
      unique case (st)
        GS_COLLECT: begin
          if (addr_reject) rej_seen <= 1'b1;
          if (acc) begin
            if (win_full) begin
              col_cnt    <= '0;
              rej_seen   <= 1'b0;
              rd_ptr     <= '0;
              end_staged <= in_last;
              if (rej_seen || addr_reject) st <= in_last ? GS_COLLECT : GS_DROP;
              else                         st <= GS_DRAIN;
            end else if (in_last) begin
              col_cnt  <= '0;
              rej_seen <= 1'b0;
            end else begin
              col_cnt <= col_cnt + CNW'(1);
            end
          end
        end
        GS_DRAIN: begin
          if (wr_fire) begin
            rd_ptr <= rd_ptr + SAW'(1);
            if (spill_fail)                      st <= end_staged ? GS_COLLECT : GS_DROP;
            else if (rd_ptr == SAW'(WIN - 1))    st <= end_staged ? GS_COLLECT : GS_LIVE;
          end
        end
        GS_LIVE: begin
          if (wr_fire) begin
            if (in_last)         st <= GS_COLLECT;
            else if (spill_fail) st <= GS_DROP;
          end
        end
        default: begin
          if (acc && in_last) st <= GS_COLLECT;
        end
      endcase
    end
  end
endmodule

// File: rtl/rxg_check.sv
module rxg_check #(
  parameter int WIN       = 64,
  parameter int BUF_BYTES = 48,
  localparam int CNW = $clog2(WIN + 1),
  localparam int BAW = $clog2(BUF_BYTES),
  localparam int BCW = $clog2(BUF_BYTES + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           in_last,
  input logic           wr_valid,
  input logic [BAW-1:0] wr_addr,
  input logic           buf_done,
  input logic           buf_last,
  input logic [BCW-1:0] buf_count,
  input logic           buf_irq,
  input logic           desc_advance,
  input logic           overrun
);
  logic [CNW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && in_ready) begin
      if (in_last)                    seen <= '0;
      else if (seen != CNW'(WIN))     seen <= seen + CNW'(1);
    end
  end

  // R3: writes only once a whole window has been taken in
  a_r3_window_first: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (seen == '0 || seen == CNW'(WIN)));

  // R6: write address stays inside the buffer
  a_r6_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr < BAW'(BUF_BYTES)));

  // R7: descriptor advance only on a non-final close
  a_r7_advance_close: assert property (@(posedge clk) disable iff (!rst_n)
    desc_advance |-> (buf_done && !buf_last));

  // R8: overrun rises together with a spill request
  a_r8_ovr_spill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> desc_advance);

  // R9: a final close carries a valid byte count
  a_r9_last_count: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_done && buf_last) |-> (buf_count != '0 && buf_count <= BCW'(BUF_BYTES)));

  // R10: interrupt only with a close
  a_r10_irq_done: assert property (@(posedge clk) disable iff (!rst_n)
    buf_irq |-> buf_done);
endmodule

bind rx_window_gate rxg_check #(.WIN(WIN), .BUF_BYTES(BUF_BYTES)) u_rxg_check (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_last      (in_last),
  .wr_valid     (wr_valid),
  .wr_addr      (wr_addr),
  .buf_done     (buf_done),
  .buf_last     (buf_last),
  .buf_count    (buf_count),
  .buf_irq      (buf_irq),
  .desc_advance (desc_advance),
  .overrun      (overrun)
);

// File: tb/rx_window_gate_bench.sv
module rx_window_gate_bench;
  localparam int WIN = 64;
  localparam int BUFB = 48;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, addr_reject = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, filt_chk, wr_valid;
  logic       wr_ready = 1'b0;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;
  logic       next_desc_empty = 1'b1, irq_en = 1'b1;
  logic       buf_done, buf_last, buf_irq, desc_advance, overrun;
  logic [5:0] buf_count;

  int checks = 0, errors = 0;
  int chk_seen = 0, adv_seen = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [13:0] wq [$];   // {addr, data}
  logic [7:0]  cq [$];   // {last, irq, count}

  always #4 clk = ~clk;

  rx_window_gate u_rx_window_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .addr_reject(addr_reject),
    .filt_chk(filt_chk), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .next_desc_empty(next_desc_empty),
    .irq_en(irq_en), .buf_done(buf_done), .buf_last(buf_last),
    .buf_count(buf_count), .buf_irq(buf_irq), .desc_advance(desc_advance),
    .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // random write-port stalls
  always @(posedge clk) begin
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready <= rst_n && (lfsr[1:0] != 2'b00);
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid && wr_ready) begin
        if (wq.size() == 0) check(1'b0, "R3/R4 unexpected write", int'(wr_addr), -1);
        else begin
          logic [13:0] e;
          e = wq.pop_front();
          check(wr_addr == e[13:8], "R6 addr", int'(wr_addr), int'(e[13:8]));
          check(wr_data == e[7:0], "R6 data", int'(wr_data), int'(e[7:0]));
        end
      end
      if (in_valid && wr_valid && !wr_ready && in_ready)
        check(1'b0, "R1 in_ready under stall", 1, 0);
      if (buf_done) begin
        if (cq.size() == 0) check(1'b0, "R9 unexpected close", int'(buf_count), -1);
        else begin
          logic [7:0] e;
          e = cq.pop_front();
          check(buf_last == e[7], "R9/R7 last flag", int'(buf_last), int'(e[7]));
          check(buf_count == e[5:0], "R9/R7 count", int'(buf_count), int'(e[5:0]));
          check(buf_irq == e[6], "R10 irq", int'(buf_irq), int'(e[6]));
        end
      end else if (buf_irq) check(1'b0, "R10 irq without close", 1, 0);
      if (filt_chk) chk_seen++;
      if (desc_advance) adv_seen++;
    end
  end

  task automatic run_frame(input int len, input int rej_at, input bit nxt, input bit msk,
                           input logic [7:0] seed, input string tag);
    bit keep;
    int pos, exp_adv;
    bit exp_ovr;
    keep = (len >= WIN) && !(rej_at >= 1 && rej_at <= WIN);
    pos = 0; exp_adv = 0; exp_ovr = 1'b0;
    chk_seen = 0; adv_seen = 0;
    if (keep) begin
      for (int i = 0; i < len; i++) begin
        wq.push_back({6'(pos), 8'(seed + i)});
        pos++;
        if (i == len - 1) begin
          cq.push_back({1'b1, msk, 6'(pos)});
        end else if (pos == BUFB) begin
          cq.push_back({1'b0, msk, 6'(BUFB)});
          exp_adv++;
          pos = 0;
          if (!nxt) begin exp_ovr = 1'b1; break; end
        end
      end
    end
    next_desc_empty = nxt;
    irq_en = msk;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      in_valid    = 1'b1;
      in_data     = 8'(seed + i);
      in_last     = (i == len - 1);
      addr_reject = (i + 1 == rej_at);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; addr_reject = 1'b0;
    repeat (WIN + 20) @(negedge clk);
    check(wq.size() == 0, {tag, " pending writes"}, wq.size(), 0);
    check(cq.size() == 0, {tag, " pending closes"}, cq.size(), 0);
    check(chk_seen == (len >= 8 ? 1 : 0), {tag, " R2 filter request"}, chk_seen, len >= 8 ? 1 : 0);
    check(adv_seen == exp_adv, {tag, " R7 advances"}, adv_seen, exp_adv);
    check(overrun == exp_ovr, {tag, " R8 overrun"}, int'(overrun), int'(exp_ovr));
    wq.delete(); cq.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R11 in_ready", int'(in_ready), 1);
    check(!wr_valid && !buf_done && !buf_irq, "R11 idle outputs", int'(wr_valid), 0);
    check(!desc_advance && !filt_chk && !overrun, "R11 flags", int'(overrun), 0);
    run_frame(40,  0,  1'b1, 1'b1, 8'h10, "R3 short40");
    run_frame(63,  0,  1'b1, 1'b1, 8'h20, "R3 short63");
    run_frame(64,  0,  1'b1, 1'b1, 8'h30, "R9 exact64");
    run_frame(100, 10, 1'b1, 1'b1, 8'h40, "R4 rej10");
    run_frame(80,  64, 1'b1, 1'b1, 8'h50, "R4 rej64");
    run_frame(100, 70, 1'b1, 1'b1, 8'h60, "R5 rej70");
    run_frame(96,  0,  1'b1, 1'b0, 8'h70, "R10 mask0");
    run_frame(120, 0,  1'b0, 1'b1, 8'h80, "R8 full next");
    run_frame(70,  0,  1'b1, 1'b1, 8'h90, "R8 clear");
    run_frame(200, 0,  1'b1, 1'b1, 8'hA0, "R1 R7 multi spill");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule